// File: doc/BRIEF.md
# Cache Parity Control and Status Register

This block is a 32-bit control register that sits beside a processor's cache parity logic. Software reaches it with move-to and move-from special-register operations at one fixed address. The control fields drive a parity-check enable for each of three checked structures: the L1 instruction side, the L1 data side and the L2 tag. They also drive five force-bad-parity injection lines and a limit on outstanding store misses for the load/store unit.

Each of the three parity checkers sends a one-cycle error pulse. A pulse that arrives while its structure is enabled sets a sticky status bit. Software clears a status bit by writing 0 to it; writing 1 to a status bit leaves it as it is. An interrupt output stays high while any enabled structure has its status bit set.

Bits are numbered big-endian: bit 0 is the MSB (vector index 31) and bit n sits at vector index 31-n.

Top module: `parity_ctl_reg`

## Requirements
- R1: Reads and writes act only at special-register address 1016. A write to any other address changes nothing. A read at any other address returns 0.
- R2: The reserved bits 0:2, 4:19 and 28 always read as 0. Writes do not change them.
- R3: Bit 3 (vector index 28) limits outstanding store misses. When it is 1, `store_miss_limit` is 1; when it is 0, `store_miss_limit` is 2.
- R4: Bits 20 to 24 drive `inj_bad_par[0]` to `inj_bad_par[4]` in that order. The five targets are instruction-cache data, instruction-cache tag, data-cache data, data-cache tag and L2 tag.
- R5: Bits 29, 30 and 31 drive `par_chk_en[0]` (instruction side), `par_chk_en[1]` (data side) and `par_chk_en[2]` (L2 tag).
- R6: An error pulse on `chk_err[i]` while `par_chk_en[i]` is 1 sets status bit 25+i. The bit stays set until software clears it.
- R7: An error pulse that arrives while its enable is 0 is dropped.
- R8: Writing 0 to a status bit clears it. Writing 1 to a status bit leaves it unchanged, and a write never sets a status bit.
- R9: If an enabled error pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: `spr_rdata` shows the register value in the cycle after a read request. The value shown is the one from before any write in the same cycle. In all other cycles `spr_rdata` is 0.
- R11: While `rst_n` is low at a clock edge, every field is cleared to 0.
- R12: `par_err_irq` is 1 exactly when at least one status bit is set and its enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spr_wr_en | input | 1 | Move-to special-register request |
| spr_rd_en | input | 1 | Move-from special-register request |
| spr_addr | input | 10 | Special-register number |
| spr_wdata | input | 32 | Write data, bit 0 = MSB |
| spr_rdata | output | 32 | Read data, one cycle after the request |
| chk_err | input | 3 | Error pulses: [0] instruction side, [1] data side, [2] L2 tag |
| par_chk_en | output | 3 | Parity-check enables, same order as chk_err |
| inj_bad_par | output | 5 | Force-bad-parity controls for IC data, IC tag, DC data, DC tag and L2 tag |
| store_miss_limit | output | 2 | Allowed outstanding store misses (1 or 2) |
| par_err_irq | output | 1 | Parity error interrupt |

## Verification
The hardest case to reach from the ports is an enabled error pulse landing in the same cycle as a write that clears the same status bit. Close behind it is a pulse that arrives in a window where its enable is off. Directed sequences build both cases on purpose: they enable a structure, fire the checker, and then fire it again together with a clearing write or after disabling. A long random phase then drives error pulses, writes, reads and off-address accesses at the same time. This covers the remaining overlaps, each checked against a reference model kept in the bench.

// File: rtl/parity_ctl_pkg.sv
// Package: field positions and masks for the parity control register.
// Assumes big-endian field numbering (bit 0 = MSB = vector index 31).
package parity_ctl_pkg;
    localparam int WORD_W   = 32;
    localparam int NUM_CHK  = 3;
    localparam int NUM_INJ  = 5;

    // map a big-endian bit number onto a vector index
    function automatic int be_idx(input int n);
        return WORD_W - 1 - n;
    endfunction

    localparam int IDX_STORE_LIM = be_idx(3);
    localparam int IDX_INJ_FIRST = be_idx(20);   // inj[k] sits at be_idx(20+k)
    localparam int IDX_ST_FIRST  = be_idx(25);   // status[i] at be_idx(25+i)
    localparam int IDX_EN_FIRST  = be_idx(29);   // enable[i] at be_idx(29+i)

    localparam logic [WORD_W-1:0] RSVD_MASK = 32'hEFFF_F008;
endpackage

// File: rtl/parity_ctl_fields.sv
// Module: parity_ctl_fields
// Holds the software-owned control fields: store-limit disable, injection
// controls and check enables. Assumes wr_hit is already qualified by address.
module parity_ctl_fields
    import parity_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [WORD_W-1:0]  wdata,
    output logic               lim_dis,
    output logic [NUM_INJ-1:0] inj,
    output logic [NUM_CHK-1:0] en
);
    logic [NUM_INJ-1:0] inj_wr;
    logic [NUM_CHK-1:0] en_wr;

    // gather write fields from their big-endian positions
    always_comb begin
        for (int k = 0; k < NUM_INJ; k++) inj_wr[k] = wdata[IDX_INJ_FIRST - k];
        for (int i = 0; i < NUM_CHK; i++) en_wr[i]  = wdata[IDX_EN_FIRST - i];
    end

    // control field storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_dis <= 1'b0;
            inj     <= '0;
            en      <= '0;
        end else if (wr_hit) begin
            lim_dis <= wdata[IDX_STORE_LIM];
            inj     <= inj_wr;
            en      <= en_wr;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (en == $past(en_wr)) && (inj == $past(inj_wr))) else $error("write lost"); // R5
endmodule

// File: rtl/parity_ctl_status.sv
// Module: parity_ctl_status
// One sticky parity status bit. Hardware set has priority over a software
// clear. Assumes err is a pulse from the checker and en is the current enable.
module parity_ctl_status (
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic en,
    input  logic wr_hit,
    input  logic wbit,
    output logic st
);
    logic set_req;
    logic keep;

    // qualify the checker pulse and the write-zero clear
    always_comb begin
        set_req = err & en;
        keep    = st & ~(wr_hit & ~wbit);
    end

    // sticky status storage
    always_ff @(posedge clk) begin
        if (!rst_n) st <= 1'b0;
        else        st <= keep | set_req;
    end

    AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !st) |=> !st) else $error("set while disabled"); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err && en) |=> st) else $error("error lost"); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wbit && !(err && en)) |=> !st) else $error("clear failed"); // R8
    AST_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st && !(err && en)) |=> !st) else $error("write set status"); // R8
endmodule

// File: rtl/parity_ctl_rdport.sv
// Module: parity_ctl_rdport
// Registered read port: returns the word one cycle after a read hit, else 0.
module parity_ctl_rdport
    import parity_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] rdata
);
    // capture the current word on a read hit
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_hit) rdata <= word;
        else             rdata <= '0;
    end
endmodule

// File: rtl/parity_ctl_reg.sv
// Module: parity_ctl_reg (top)
// Parity control/status register at one special-register address. It assumes
// single-cycle error pulses and at most one access per cycle per direction.
module parity_ctl_reg
    import parity_ctl_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int SPR_NUM = 1016
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spr_wr_en,
    input  logic              spr_rd_en,
    input  logic [ADDR_W-1:0] spr_addr,
    input  logic [31:0]       spr_wdata,
    output logic [31:0]       spr_rdata,
    input  logic [2:0]        chk_err,
    output logic [2:0]        par_chk_en,
    output logic [4:0]        inj_bad_par,
    output logic [1:0]        store_miss_limit,
    output logic              par_err_irq
);
    logic               addr_hit, wr_hit, rd_hit, lim_dis;
    logic [NUM_CHK-1:0] st;
    logic [WORD_W-1:0]  word;

    // decode the special-register number
    always_comb begin
        addr_hit = (spr_addr == ADDR_W'(SPR_NUM));
        wr_hit   = spr_wr_en & addr_hit;
        rd_hit   = spr_rd_en & addr_hit;
    end

    parity_ctl_fields u_fields (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(spr_wdata),
        .lim_dis(lim_dis), .inj(inj_bad_par), .en(par_chk_en)
    );

    for (genvar i = 0; i < NUM_CHK; i++) begin : g_st
        parity_ctl_status u_st (
            .clk(clk), .rst_n(rst_n), .err(chk_err[i]), .en(par_chk_en[i]),
            .wr_hit(wr_hit), .wbit(spr_wdata[IDX_ST_FIRST - i]), .st(st[i])
        );
    end

    // assemble the architectural word; reserved bits stay 0
    always_comb begin
        word = '0;
        word[IDX_STORE_LIM] = lim_dis;
        for (int k = 0; k < NUM_INJ; k++) word[IDX_INJ_FIRST - k] = inj_bad_par[k];
        for (int i = 0; i < NUM_CHK; i++) begin
            word[IDX_ST_FIRST - i] = st[i];
            word[IDX_EN_FIRST - i] = par_chk_en[i];
        end
    end

    parity_ctl_rdport u_rd (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .word(word), .rdata(spr_rdata)
    );

    // outputs to the load/store unit and the interrupt logic
    always_comb begin
        store_miss_limit = lim_dis ? 2'd1 : 2'd2;
        par_err_irq      = |(st & par_chk_en);
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_rdata & RSVD_MASK) == '0) else $error("reserved bit set"); // R2
    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_wr_en && !addr_hit) |=> $stable(par_chk_en) && $stable(inj_bad_par)) else $error("stray write"); // R1
    AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        store_miss_limit == 2'd1 || store_miss_limit == 2'd2) else $error("bad limit"); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_irq && !spr_wr_en) |=> par_err_irq) else $error("irq dropped"); // R12
endmodule

// File: tb/sim_parity_ctl_reg.sv
module sim_parity_ctl_reg;
    logic clk = 1'b0, rst_n = 1'b0;
    logic spr_wr_en = 0, spr_rd_en = 0;
    logic [9:0]  spr_addr = 0;
    logic [31:0] spr_wdata = 0, spr_rdata;
    logic [2:0]  chk_err = 0, par_chk_en;
    logic [4:0]  inj_bad_par;
    logic [1:0]  store_miss_limit;
    logic        par_err_irq;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [31:0] model = 0, exp_rd = 0;

    always #4 clk = ~clk;

    parity_ctl_reg u0 (.*);

    function automatic int bi(int n); return 31 - n; endfunction

    // reference next-state of the register word
    function automatic logic [31:0] nxt(logic [31:0] m, logic wr, logic [31:0] wd, logic [2:0] e);
        logic [31:0] r;
        r = wr ? (wd & 32'h1000_0F87) : (m & 32'h1000_0F87);
        for (int i = 0; i < 3; i++) begin
            logic s;
            s = m[bi(25 + i)];
            if (wr) s = s & wd[bi(25 + i)];
            s = s | (e[i] & m[bi(29 + i)]);
            r[bi(25 + i)] = s;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs();
        logic [2:0] en; logic [4:0] inj; logic [2:0] st;
        for (int i = 0; i < 3; i++) begin en[i] = model[bi(29+i)]; st[i] = model[bi(25+i)]; end
        for (int k = 0; k < 5; k++) inj[k] = model[bi(20+k)];
        chk(spr_rdata === exp_rd, "R10 rdata", spr_rdata, exp_rd);
        chk((spr_rdata & 32'hEFFF_F008) == 0, "R2 reserved", spr_rdata, 0);
        chk(par_chk_en === en, "R5 enables", 32'(par_chk_en), 32'(en));
        chk(inj_bad_par === inj, "R4 inject", 32'(inj_bad_par), 32'(inj));
        chk(store_miss_limit === (model[bi(3)] ? 2'd1 : 2'd2), "R3 limit",
            32'(store_miss_limit), model[bi(3)] ? 1 : 2);
        chk(par_err_irq === |(st & en), "R12 irq", 32'(par_err_irq), 32'(|(st & en)));
    endtask

    // one clock of stimulus, driven at the falling edge, checked at the next
    task automatic step(logic wr, logic rd, logic [9:0] a, logic [31:0] wd, logic [2:0] e);
        logic [31:0] nm;
        spr_wr_en = wr; spr_rd_en = rd; spr_addr = a; spr_wdata = wd; chk_err = e;
        nm = nxt(model, wr && a == 10'd1016, wd, e);
        exp_rd = (rd && a == 10'd1016) ? model : 32'h0;
        if (!rst_n) begin nm = 0; exp_rd = 0; end
        @(posedge clk); @(negedge clk);
        model = nm;
        spr_wr_en = 0; spr_rd_en = 0; chk_err = 0;
        check_outs();
    endtask

    task automatic wr(logic [31:0] d, logic [2:0] e = 0); step(1, 0, 10'd1016, d, e); endtask

    task automatic expect_rd(logic [31:0] exp, string req);
        step(0, 1, 10'd1016, 0, 0);
        chk(spr_rdata === exp, req, spr_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk); @(negedge clk);
        // R11: reset state
        chk(spr_rdata === 0 && par_chk_en === 0 && inj_bad_par === 0 && !par_err_irq,
            "R11 reset outs", spr_rdata, 0);
        chk(store_miss_limit === 2'd2, "R11 reset limit", 32'(store_miss_limit), 2);
        rst_n = 1;
        @(negedge clk);
        wr(32'hFFFF_FFFF);
        expect_rd(32'h1000_0F87, "R2 R8 all-ones write");
        wr(32'h0);
        step(0, 0, 10'd1016, 0, 3'b111);
        expect_rd(32'h0, "R7 disabled drop");
        wr(32'h7);
        step(0, 0, 10'd1016, 0, 3'b111);
        expect_rd(32'h77, "R6 sticky set");
        chk(par_err_irq === 1'b1, "R12 irq high", 32'(par_err_irq), 1);
        wr(32'h77);
        expect_rd(32'h77, "R8 write one keeps");
        wr(32'h37);
        expect_rd(32'h37, "R8 clear instr side");
        wr(32'h7, 3'b001);
        expect_rd(32'h47, "R9 set beats clear");
        step(1, 0, 10'd1015, 32'h0, 0);
        expect_rd(32'h47, "R1 other address write");
        step(0, 1, 10'd1015, 0, 0);
        chk(spr_rdata === 0, "R1 other address read", spr_rdata, 0);
        wr(32'h1000_0000);
        chk(store_miss_limit === 2'd1, "R3 limit one", 32'(store_miss_limit), 1);
        expect_rd(32'h1000_0000, "R7 disable drops status view");
        for (int n = 0; n < 4000; n++) begin
            logic [9:0] a;
            a = ($urandom % 8 == 0) ? 10'($urandom) : 10'd1016;
            step(1'($urandom % 3 == 0), 1'($urandom), a, $urandom, 3'($urandom % 8 & $urandom % 8));
        end
        wr(32'h1000_0FF7);
        rst_n = 0;
        step(1, 1, 10'd1016, 32'hFFFF_FFFF, 3'b111);
        rst_n = 1;
        expect_rd(32'h0, "R11 reset clears");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule